// File: doc/BRIEF.md
# Tile Layer Priority Compositor

This block takes, for every screen position, the two pixels already chosen from the two tile-layer pairs and produces two finished image planes. One plane goes beneath an externally rendered 3D image and one goes on top of it. Each pixel carries a palette bank, a raw pattern code and a flag that tells which layer of its pair it came from. The block builds palette addresses from these fields according to each layer's colour depth. It reads both palette words through a two-lane read port with one cycle of latency. It then sorts the two pixels into the planes by per-layer priority bits and resolves coverage and transparency within each plane. The winning colour in each plane is widened to 8 bits per channel and adjusted by the signed offset of the winner's pair.

The pipeline is two registers deep. A pixel presented with `pix_valid` at one rising edge appears with `out_valid` two edges later. Every control input (enables, priority, depth, offsets) is captured together with the pixel it accompanies. Blending the planes with the 3D image and loading the palette are handled elsewhere.

Top module: `tile_layer_compositor`

## Requirements
- R1: Layer number is 2×pair + select bit (pair 0 gives layers 0/1, pair 1 gives layers 2/3). When `layer_depth[layer]` is 1 (4-bit colour) the palette address is {bank[10:0], code[3:0]}. When it is 0 (8-bit colour) the address is {bank[6:0], code[7:0]}. The pair 0 address drives `pal_rd_addr[14:0]` and the pair 1 address drives `pal_rd_addr[29:15]`, combinationally from the inputs.
- R2: `out_valid` rises exactly two rising edges after the edge that sampled `pix_valid` high, and it is low after reset. While `out_valid` is low, both alphas are low.
- R3: A layer whose `layer_prio` bit is 1 contributes to the top plane only. A layer whose bit is 0 contributes to the bottom plane only.
- R4: A layer whose `layer_en` bit is 0 contributes to neither plane.
- R5: When both pixels contribute to the same plane and the pair 0 pixel is opaque, the plane shows the pair 0 colour (the lower-numbered layer covers).
- R6: A palette word with bit 15 set is transparent. A transparent pair 0 pixel lets a contributing pair 1 pixel in the same plane show through.
- R7: The bottom-most contributor of a plane (pair 1 if it contributes, else pair 0) is shown even when its palette word is transparent.
- R8: A plane with no contributor outputs alpha 0 and RGB 0. Otherwise it outputs alpha 1.
- R9: Palette bits [4:0] are red, [9:5] green and [14:10] blue. Each 5-bit channel c widens to 8 bits as {c, c[4:2]}. Output RGB packs red in [23:16], green in [15:8] and blue in [7:0].
- R10: Each widened channel has the signed 8-bit offset of the winner's pair added to it: `ofs_pair_a` for pair 0 and `ofs_pair_b` for pair 1, with red in [23:16], green in [15:8] and blue in [7:0]. The result saturates to 0..255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | A pixel pair is presented this cycle |
| pix_sel | input | 2 | Per pair: 0 picks the even layer, 1 the odd layer |
| pix_bank | input | 22 | Per pair palette bank field, pair 0 in [10:0] |
| pix_code | input | 16 | Per pair raw pattern code, pair 0 in [7:0] |
| layer_en | input | 4 | Per-layer enable |
| layer_prio | input | 4 | Per-layer plane: 1 above 3D, 0 below |
| layer_depth | input | 4 | Per-layer depth: 1 is 4-bit, 0 is 8-bit |
| ofs_pair_a | input | 24 | Signed RGB offset for pair 0 |
| ofs_pair_b | input | 24 | Signed RGB offset for pair 1 |
| pal_rd_addr | output | 30 | Two palette read addresses, pair 0 in [14:0] |
| pal_rd_data | input | 32 | Palette words one cycle after the address, pair 0 in [15:0] |
| out_valid | output | 1 | Output planes carry a result |
| bot_alpha | output | 1 | Bottom plane has a contributor |
| bot_rgb | output | 24 | Bottom plane colour |
| top_alpha | output | 1 | Top plane has a contributor |
| top_rgb | output | 24 | Top plane colour |

## Verification
The sharpest case arises when the transparency fallback and offset saturation fall in the same cycle. A transparent pair 0 pixel hands the plane to pair 1, so the offset applied must switch to pair 1's register in that same cycle. The bench provokes this by giving the two pairs opposite extreme offsets (+127 and −128) while the pair 0 pixel is transparent. It judges the result against a behavioural painter's-order model, which must see the pair 1 colour pulled down and clamped at zero. The same stimulus with placement split across the two planes shows both clamps at once, one per plane.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
    localparam int TLC_PAIRS    = 2;
    localparam int TLC_PLANES   = 2;
    localparam int TLC_BANK_W   = 11;
    localparam int TLC_CODE_W   = 8;
    localparam int TLC_IDX_W    = 15;
    localparam int TLC_CH_IN_W  = 5;
    localparam int TLC_CH_OUT_W = 8;
    localparam int TLC_OFS_W    = 8;

    typedef enum logic {
        PLANE_BELOW = 1'b0,
        PLANE_ABOVE = 1'b1
    } plane_e;
endpackage

// File: rtl/tlc_addr_gen.sv
module tlc_addr_gen #(
    parameter int LAYERS  = 4,
    parameter int BANK_W  = 11,
    parameter int CODE_W  = 8,
    parameter int IDX_W   = 15,
    parameter int PAIR_ID = 0,
    parameter int LSEL_W  = $clog2(LAYERS)
) (
    input  logic              sel_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LAYERS-1:0] depth4_i,
    output logic [LSEL_W-1:0] layer_o,
    output logic [IDX_W-1:0]  addr_o
);
    localparam int NIB_W    = 4;
    localparam int NARROW_B = IDX_W - NIB_W;
    localparam int WIDE_B   = IDX_W - CODE_W;
    localparam logic [LSEL_W-2:0] PAIR_CODE = (LSEL_W-1)'(PAIR_ID);

    always_comb begin
        layer_o = {PAIR_CODE, sel_i};
        if (depth4_i[layer_o]) begin
            addr_o = {bank_i[NARROW_B-1:0], code_i[NIB_W-1:0]};
        end else begin
            addr_o = {bank_i[WIDE_B-1:0], code_i};
        end
    end
endmodule

// File: rtl/tlc_plane_pick.sv
module tlc_plane_pick #(
    parameter int PAIRS = 2,
    parameter int IW    = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic [PAIRS-1:0] hit_i,
    input  logic [PAIRS-1:0] transp_i,
    output logic             present_o,
    output logic [IW-1:0]    win_o
);
    // Painter's order: highest pair first, later pairs replace it when opaque.
    always_comb begin
        present_o = 1'b0;
        win_o     = '0;
        for (int p = PAIRS - 1; p >= 0; p--) begin
            if (hit_i[p] && (!present_o || !transp_i[p])) begin
                present_o = 1'b1;
                win_o     = IW'(p);
            end
        end
    end
endmodule

// File: rtl/tlc_chan_offset.sv
module tlc_chan_offset #(
    parameter int IN_W  = 5,
    parameter int OUT_W = 8,
    parameter int OFS_W = 8
) (
    input  logic [IN_W-1:0]  chan_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [OUT_W-1:0] chan_o
);
    localparam int REP_W = OUT_W - IN_W;
    localparam int SUM_W = OUT_W + 2;

    logic [OUT_W-1:0]        wide;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        wide = {chan_i, chan_i[IN_W-1 -: REP_W]};
        sum  = $signed({2'b00, wide}) + $signed({{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
        if (sum[SUM_W-1]) begin
            chan_o = '0;
        end else if (sum[OUT_W]) begin
            chan_o = '1;
        end else begin
            chan_o = sum[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/tile_layer_compositor.sv
module tile_layer_compositor
    import tlc_pkg::*;
#(
    parameter int BANK_W   = TLC_BANK_W,
    parameter int CODE_W   = TLC_CODE_W,
    parameter int IDX_W    = TLC_IDX_W,
    parameter int CH_IN_W  = TLC_CH_IN_W,
    parameter int CH_OUT_W = TLC_CH_OUT_W,
    parameter int OFS_W    = TLC_OFS_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pix_valid,
    input  logic [TLC_PAIRS-1:0]         pix_sel,
    input  logic [TLC_PAIRS*BANK_W-1:0]  pix_bank,
    input  logic [TLC_PAIRS*CODE_W-1:0]  pix_code,
    input  logic [2*TLC_PAIRS-1:0]       layer_en,
    input  logic [2*TLC_PAIRS-1:0]       layer_prio,
    input  logic [2*TLC_PAIRS-1:0]       layer_depth,
    input  logic [3*OFS_W-1:0]           ofs_pair_a,
    input  logic [3*OFS_W-1:0]           ofs_pair_b,
    output logic [TLC_PAIRS*IDX_W-1:0]   pal_rd_addr,
    input  logic [TLC_PAIRS*(3*CH_IN_W+1)-1:0] pal_rd_data,
    output logic                         out_valid,
    output logic                         bot_alpha,
    output logic [3*CH_OUT_W-1:0]        bot_rgb,
    output logic                         top_alpha,
    output logic [3*CH_OUT_W-1:0]        top_rgb
);
    localparam int PAIRS  = TLC_PAIRS;
    localparam int PLANES = TLC_PLANES;
    localparam int LAYERS = 2 * PAIRS;
    localparam int LSEL_W = $clog2(LAYERS);
    localparam int PW     = $clog2(PAIRS);
    localparam int PAL_W  = 3 * CH_IN_W + 1;
    localparam int RGB_W  = 3 * CH_OUT_W;
    localparam int OFS3_W = 3 * OFS_W;

    typedef struct packed {
        logic                               valid;
        logic [PAIRS-1:0][PLANES-1:0]       hit;
        logic [PAIRS-1:0][OFS3_W-1:0]       ofs;
    } stage1_t;

    typedef struct packed {
        logic                               valid;
        logic [PLANES-1:0]                  alpha;
        logic [PLANES-1:0][RGB_W-1:0]       rgb;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } state_t;

    state_t st_d, st_q;

    logic [PAIRS-1:0][LSEL_W-1:0]  layer_num;
    logic [PAIRS-1:0]              en_of;
    logic [PAIRS-1:0]              prio_of;
    logic [PAIRS-1:0][PAL_W-1:0]   pal_word;
    logic [PAIRS-1:0]              transp;
    logic [PAIRS-1:0][OFS3_W-1:0]  ofs_in;
    logic [PLANES-1:0][PAIRS-1:0]  plane_hit;
    logic [PLANES-1:0]             present;
    logic [PLANES-1:0][PW-1:0]     win;
    logic [PLANES-1:0][PAL_W-1:0]  win_word;
    logic [PLANES-1:0][OFS3_W-1:0] win_ofs;
    logic [PLANES-1:0][RGB_W-1:0]  sat_rgb;

    assign pal_word  = pal_rd_data;
    assign ofs_in[0] = ofs_pair_a;
    assign ofs_in[1] = ofs_pair_b;

    // Stage 0: address formation per pair
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        tlc_addr_gen #(
            .LAYERS (LAYERS),
            .BANK_W (BANK_W),
            .CODE_W (CODE_W),
            .IDX_W  (IDX_W),
            .PAIR_ID(p),
            .LSEL_W (LSEL_W)
        ) u_addr (
            .sel_i   (pix_sel[p]),
            .bank_i  (pix_bank[p*BANK_W +: BANK_W]),
            .code_i  (pix_code[p*CODE_W +: CODE_W]),
            .depth4_i(layer_depth),
            .layer_o (layer_num[p]),
            .addr_o  (pal_rd_addr[p*IDX_W +: IDX_W])
        );
        assign en_of[p]   = layer_en[layer_num[p]];
        assign prio_of[p] = layer_prio[layer_num[p]];
        assign transp[p]  = pal_word[p][PAL_W-1];
    end

    // Stage 1: plane resolution and colour adjustment
    for (genvar pl = 0; pl < PLANES; pl++) begin : g_plane
        for (genvar p = 0; p < PAIRS; p++) begin : g_col
            assign plane_hit[pl][p] = st_q.s1.hit[p][pl];
        end

        tlc_plane_pick #(
            .PAIRS(PAIRS),
            .IW   (PW)
        ) u_pick (
            .hit_i    (plane_hit[pl]),
            .transp_i (transp),
            .present_o(present[pl]),
            .win_o    (win[pl])
        );

        assign win_word[pl] = pal_word[win[pl]];
        assign win_ofs[pl]  = st_q.s1.ofs[win[pl]];

        for (genvar ch = 0; ch < 3; ch++) begin : g_chan
            tlc_chan_offset #(
                .IN_W (CH_IN_W),
                .OUT_W(CH_OUT_W),
                .OFS_W(OFS_W)
            ) u_chan (
                .chan_i(win_word[pl][ch*CH_IN_W +: CH_IN_W]),
                .ofs_i (win_ofs[pl][(2-ch)*OFS_W +: OFS_W]),
                .chan_o(sat_rgb[pl][(2-ch)*CH_OUT_W +: CH_OUT_W])
            );
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.s1.valid = pix_valid;
        for (int p = 0; p < PAIRS; p++) begin
            for (int pl = 0; pl < PLANES; pl++) begin
                st_d.s1.hit[p][pl] = pix_valid && en_of[p] && (prio_of[p] == 1'(pl));
            end
            st_d.s1.ofs[p] = ofs_in[p];
        end
        st_d.s2.valid = st_q.s1.valid;
        for (int pl = 0; pl < PLANES; pl++) begin
            st_d.s2.alpha[pl] = present[pl];
            st_d.s2.rgb[pl]   = present[pl] ? sat_rgb[pl] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.s2.valid;
    assign bot_alpha = st_q.s2.alpha[PLANE_BELOW];
    assign bot_rgb   = st_q.s2.rgb[PLANE_BELOW];
    assign top_alpha = st_q.s2.alpha[PLANE_ABOVE];
    assign top_rgb   = st_q.s2.rgb[PLANE_ABOVE];
endmodule

// File: rtl/tile_layer_compositor_chk.sv
module tile_layer_compositor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_valid,
    input logic [15:0] pix_code,
    input logic [3:0]  layer_en,
    input logic [3:0]  layer_prio,
    input logic [29:0] pal_rd_addr,
    input logic        out_valid,
    input logic        bot_alpha,
    input logic [23:0] bot_rgb,
    input logic        top_alpha,
    input logic [23:0] top_rgb
);
    AST_ADDR_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pal_rd_addr[3:0] == pix_code[3:0]) && (pal_rd_addr[18:15] == pix_code[11:8])); // R1

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid, 2)); // R2

    AST_ALPHA_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bot_alpha || top_alpha) |-> out_valid); // R2

    AST_ALL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(layer_prio, 2) == 4'h0)) |-> !top_alpha); // R3

    AST_ALL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(layer_en, 2) == 4'h0)) |-> (!bot_alpha && !top_alpha)); // R4

    AST_EMPTY_BOT_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !bot_alpha |-> (bot_rgb == 24'h0)); // R8

    AST_EMPTY_TOP_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !top_alpha |-> (top_rgb == 24'h0)); // R8
endmodule

bind tile_layer_compositor tile_layer_compositor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .pix_code   (pix_code),
    .layer_en   (layer_en),
    .layer_prio (layer_prio),
    .pal_rd_addr(pal_rd_addr),
    .out_valid  (out_valid),
    .bot_alpha  (bot_alpha),
    .bot_rgb    (bot_rgb),
    .top_alpha  (top_alpha),
    .top_rgb    (top_rgb)
);

// File: tb/tile_layer_compositor_tb.sv
module tile_layer_compositor_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pix_valid;
    logic [1:0]  pix_sel;
    logic [21:0] pix_bank;
    logic [15:0] pix_code;
    logic [3:0]  layer_en, layer_prio, layer_depth;
    logic [23:0] ofs_pair_a, ofs_pair_b;
    logic [29:0] pal_rd_addr;
    logic [31:0] pal_rd_data;
    logic        out_valid, bot_alpha, top_alpha;
    logic [23:0] bot_rgb, top_rgb;

    always #4 clk = ~clk;

    tile_layer_compositor u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sel(pix_sel),
        .pix_bank(pix_bank), .pix_code(pix_code), .layer_en(layer_en),
        .layer_prio(layer_prio), .layer_depth(layer_depth),
        .ofs_pair_a(ofs_pair_a), .ofs_pair_b(ofs_pair_b),
        .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
        .out_valid(out_valid), .bot_alpha(bot_alpha), .bot_rgb(bot_rgb),
        .top_alpha(top_alpha), .top_rgb(top_rgb)
    );

    // Palette contents: computed, bit 15 (transparent) follows address bit 14
    function automatic logic [15:0] pal_fn(logic [14:0] a);
        logic [14:0] m;
        m = a * 15'd13 + 15'd7;
        return {a[14], m};
    endfunction

    always_ff @(posedge clk) begin
        pal_rd_data <= {pal_fn(pal_rd_addr[29:15]), pal_fn(pal_rd_addr[14:0])};
    end

    typedef struct {
        bit    v;
        bit    ba;
        bit    ta;
        int    brgb;
        int    trgb;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_chk  = 0;
    int n_fail = 0;

    function automatic int chan(int c5, int o8);
        int c8, so, v;
        c8 = (c5 << 3) | (c5 >> 2);
        so = (o8 >= 128) ? o8 - 256 : o8;
        v  = c8 + so;
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int colour(logic [15:0] w, logic [23:0] o);
        return (chan(int'(w[4:0]), int'(o[23:16])) << 16)
             | (chan(int'(w[9:5]), int'(o[15:8])) << 8)
             |  chan(int'(w[14:10]), int'(o[7:0]));
    endfunction

    function automatic int addr_of(int pair, bit sel, logic [10:0] bank,
                                   logic [7:0] code, logic [3:0] depth);
        int layer;
        layer = 2 * pair + int'(sel);
        if (depth[layer]) return int'(bank) * 16 + int'(code[3:0]);
        return int'(bank[6:0]) * 256 + int'(code);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, logic [1:0] sel, logic [10:0] ba, logic [10:0] bb,
                        logic [7:0] ca, logic [7:0] cb, logic [3:0] en,
                        logic [3:0] prio, logic [3:0] depth,
                        logic [23:0] oa, logic [23:0] ob, string tag);
        exp_t e, f;
        int ad[2];
        bit have;
        int rgb, layer;
        logic [15:0] w;
        @(negedge clk);
        if (q.size() >= 2) begin
            f = q.pop_front();
            check(f.tag, int'(out_valid), int'(f.v), "out_valid");
            if (f.v) begin
                check(f.tag, int'(bot_alpha), int'(f.ba), "bot_alpha");
                check(f.tag, int'(bot_rgb), f.brgb, "bot_rgb");
                check(f.tag, int'(top_alpha), int'(f.ta), "top_alpha");
                check(f.tag, int'(top_rgb), f.trgb, "top_rgb");
            end
        end
        pix_valid   = v;
        pix_sel     = sel;
        pix_bank    = {bb, ba};
        pix_code    = {cb, ca};
        layer_en    = en;
        layer_prio  = prio;
        layer_depth = depth;
        ofs_pair_a  = oa;
        ofs_pair_b  = ob;
        ad[0] = addr_of(0, sel[0], ba, ca, depth);
        ad[1] = addr_of(1, sel[1], bb, cb, depth);
        #1;
        check("R1", int'(pal_rd_addr[14:0]), ad[0], "pair0 address");
        check("R1", int'(pal_rd_addr[29:15]), ad[1], "pair1 address");
        e.v = v;
        e.tag = tag;
        for (int pl = 0; pl < 2; pl++) begin
            have = 0;
            rgb  = 0;
            for (int p = 1; p >= 0; p--) begin
                layer = 2 * p + int'(sel[p]);
                if (v && en[layer] && (int'(prio[layer]) == pl)) begin
                    w = pal_fn(15'(ad[p]));
                    if (!have || !w[15]) begin
                        have = 1;
                        rgb  = colour(w, (p == 0) ? oa : ob);
                    end
                end
            end
            if (pl == 0) begin e.ba = have; e.brgb = rgb; end
            else         begin e.ta = have; e.trgb = rgb; end
        end
        q.push_back(e);
    endtask

    task automatic idle();
        step(0, 2'b00, 11'h0, 11'h0, 8'h0, 8'h0, 4'h0, 4'h0, 4'h0, 24'h0, 24'h0, "R2");
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        exp_t z;
        rst_n = 1'b0;
        pix_valid = 0; pix_sel = 0; pix_bank = 0; pix_code = 0;
        layer_en = 0; layer_prio = 0; layer_depth = 0;
        ofs_pair_a = 0; ofs_pair_b = 0;
        repeat (3) @(negedge clk);
        check("R2", int'(out_valid), 0, "reset out_valid");
        check("R8", int'(bot_alpha), 0, "reset bot_alpha");
        check("R8", int'(top_alpha), 0, "reset top_alpha");
        rst_n = 1'b1;
        z.v = 0; z.ba = 0; z.ta = 0; z.brgb = 0; z.trgb = 0; z.tag = "R2";
        q.push_back(z);
        q.push_back(z);

        // R1: address formation in both depths and mixed
        step(1, 2'b10, 11'h123, 11'h456, 8'hA5, 8'h3C, 4'hF, 4'h0, 4'hF, 24'h0, 24'h0, "R1");
        step(1, 2'b01, 11'h123, 11'h456, 8'hA5, 8'h3C, 4'hF, 4'h0, 4'h0, 24'h0, 24'h0, "R1");
        step(1, 2'b00, 11'h0B7, 11'h3C1, 8'h5A, 8'hE2, 4'hF, 4'h0, 4'h4, 24'h0, 24'h0, "R1");
        // R3: plane placement
        step(1, 2'b00, 11'h015, 11'h02A, 8'h11, 8'h77, 4'hF, 4'h1, 4'h0, 24'h0, 24'h0, "R3");
        step(1, 2'b00, 11'h015, 11'h02A, 8'h11, 8'h77, 4'hF, 4'h4, 4'h0, 24'h0, 24'h0, "R3");
        step(1, 2'b11, 11'h015, 11'h02A, 8'h11, 8'h77, 4'hF, 4'hF, 4'h0, 24'h0, 24'h0, "R3");
        idle();
        // R4: disables
        step(1, 2'b00, 11'h015, 11'h02A, 8'h21, 8'h37, 4'hE, 4'h0, 4'h0, 24'h0, 24'h0, "R4");
        step(1, 2'b00, 11'h015, 11'h02A, 8'h21, 8'h37, 4'h0, 4'h5, 4'h0, 24'h0, 24'h0, "R4");
        // R5: pair 0 covers pair 1
        step(1, 2'b00, 11'h015, 11'h02A, 8'h31, 8'h47, 4'hF, 4'h0, 4'h0, 24'h0, 24'h0, "R5");
        step(1, 2'b11, 11'h015, 11'h02A, 8'h31, 8'h47, 4'hF, 4'hF, 4'h0, 24'h0, 24'h0, "R5");
        // R6: transparent pair 0 shows pair 1
        step(1, 2'b00, 11'h045, 11'h02A, 8'h31, 8'h47, 4'hF, 4'h0, 4'h0, 24'h0, 24'h0, "R6");
        step(1, 2'b00, 11'h403, 11'h02A, 8'h3F, 8'h47, 4'hF, 4'h0, 4'hF, 24'h0, 24'h0, "R6");
        // R7: bottom-most shown despite transparency
        step(1, 2'b00, 11'h045, 11'h02A, 8'h31, 8'h47, 4'hB, 4'h0, 4'h0, 24'h0, 24'h0, "R7");
        step(1, 2'b00, 11'h045, 11'h04A, 8'h31, 8'h47, 4'hF, 4'h0, 4'h0, 24'h0, 24'h0, "R7");
        step(1, 2'b00, 11'h045, 11'h04A, 8'h31, 8'h47, 4'hF, 4'h4, 4'h0, 24'h0, 24'h0, "R7");
        // R8: empty planes
        step(1, 2'b11, 11'h015, 11'h02A, 8'h31, 8'h47, 4'h5, 4'h0, 4'h0, 24'h0, 24'h0, "R8");
        idle();
        // R9: channel widening, zero offsets
        step(1, 2'b00, 11'h1F3, 11'h2A5, 8'hFF, 8'h0C, 4'hF, 4'h4, 4'hF, 24'h0, 24'h0, "R9");
        step(1, 2'b10, 11'h07F, 11'h03E, 8'hFF, 8'hC3, 4'hF, 4'h8, 4'h0, 24'h0, 24'h0, "R9");
        // R10: signed offsets and saturation per pair
        step(1, 2'b00, 11'h015, 11'h02A, 8'h31, 8'h47, 4'hF, 4'h4, 4'h0, 24'h7F7F7F, 24'h808080, "R10");
        step(1, 2'b00, 11'h045, 11'h02A, 8'h31, 8'h47, 4'hF, 4'h0, 4'h0, 24'h7F7F7F, 24'h808080, "R10");
        step(1, 2'b00, 11'h015, 11'h02A, 8'h31, 8'h47, 4'hF, 4'h0, 4'h0, 24'h10F080, 24'h0, "R10");
        step(1, 2'b00, 11'h045, 11'h02A, 8'h31, 8'h47, 4'hF, 4'h4, 4'h0, 24'h7F7F7F, 24'h808080, "R10");
        // R2: valid gaps
        idle();
        step(1, 2'b01, 11'h011, 11'h022, 8'h01, 8'h02, 4'hF, 4'h3, 4'h5, 24'h0, 24'h0, "R2");
        idle();
        idle();
        step(1, 2'b10, 11'h033, 11'h044, 8'h03, 8'h04, 4'hF, 4'hC, 4'hA, 24'h0, 24'h0, "R2");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, 2'($urandom), 11'($urandom), 11'($urandom),
                 8'($urandom), 8'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                 24'($urandom), 24'($urandom), "R5");
        end
        idle();
        idle();
        idle();
        summary();
        $finish;
    end
endmodule